// File: doc/BRIEF.md
# Branch Confidence Estimator

This block sits beside a branch direction predictor and reports whether the prediction for the branch now being fetched is likely to be right. A low-confidence answer lets the fetch unit hold off or fork instead of following the predicted path. The policy that acts on the answer is outside this block.

A table of small shift registers is indexed by bits of the branch address. Every resolved branch shifts one outcome bit into its entry: 1 when the prediction was correct, 0 when it was wrong. On lookup, the zeros in the addressed entry are counted in the same cycle. The answer is high confidence when that count does not exceed a programmable threshold. A static mode input can select a second scheme instead. In that scheme confidence is taken from the predictor's own 2-bit counter, which is supplied with the lookup address, and a weak counter state reads as low confidence.

Top module: `brconf_est`

## Requirements
- R1: After reset every entry holds all ones, so every lookup reports a zero count of 0 and high confidence in history mode for any threshold.
- R2: A training write with `tr_valid`=1 shifts `tr_correct` into bit 0 of the indexed entry, and the older bits move one place toward the MSB. The oldest bit is dropped. No other entry changes.
- R3: `lk_zeros` equals the number of 0 bits in the addressed entry. It therefore lies between 0 and HIST_W, and it reaches HIST_W after HIST_W or more consecutive mispredictions.
- R4: With `mode_weak`=0, `lk_high` is 1 exactly when `lk_zeros` <= `thresh`.
- R5: With `mode_weak`=1, `lk_high` is 0 exactly when `lk_ctr` is a weak state and 1 otherwise. The encoding is 2'b00 strong not-taken, 2'b01 weak not-taken, 2'b10 weak taken, 2'b11 strong taken. Training still updates the table in this mode.
- R6: A lookup is combinational and a training write takes effect at the next rising clock edge. A lookup to the entry being trained in the same cycle therefore sees the value from before the write.
- R7: While `tr_valid`=0, no entry changes, whatever `tr_addr` and `tr_correct` are.
- R8: The table index is address bits [IDX_W+1:2], which is [7:2] by default. Addresses that differ only in other bits share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_weak | input | 1 | Static mode: 0 counts history zeros, 1 uses weak counter state |
| thresh | input | CNT_W (4) | Largest zero count still reported as high confidence |
| lk_addr | input | ADDR_W (32) | Lookup branch address |
| lk_ctr | input | 2 | Predictor counter for the looked-up branch (weak-state mode) |
| lk_high | output | 1 | 1 = high confidence, 0 = low confidence |
| lk_zeros | output | CNT_W (4) | Number of misprediction marks in the addressed entry |
| tr_valid | input | 1 | Training write enable |
| tr_addr | input | ADDR_W (32) | Branch address of the resolved branch |
| tr_correct | input | 1 | 1 = the prediction was correct, 0 = it was wrong |

## Verification
The bench goes after the following corner cases and the fault each one exposes:
- **Threshold boundary.** When the count equals the threshold, a wrong comparison (less-than instead of less-or-equal) reports low confidence.
- **Saturation.** A long burst of mispredictions must stop at HIST_W zeros. A counter that drops the wrong end of the register never gets there.
- **Read during write.** A same-cycle lookup of an entry being trained must return the old history. A bypassed or misindexed write shows up there.
- **Shared index.** Addresses that alias must share one entry, while a neighbouring entry must stay all ones. A wrong index slice or a write that touches several entries breaks this.
- **Weak-state mode.** Strong and weak counter states must give different answers whatever the history holds.

// File: rtl/brconf_pkg.sv
package brconf_pkg;
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  function automatic logic ctr_is_weak(input logic [1:0] c);
    return (c == CTR_WEAK_NT) || (c == CTR_WEAK_T);
  endfunction
endpackage

// File: rtl/brconf_rst_sync.sv
module brconf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/brconf_hist_tbl.sv
module brconf_hist_tbl #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];
  logic [HIST_W-1:0] hist_shifted;
  logic [DEPTH-1:0]  entry_en;

  always_comb hist_shifted = {hist_q[wr_idx][HIST_W-2:0], wr_bit};

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_comb entry_en[gi] = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hist_q[gi] <= '1;
      else if (entry_en[gi]) hist_q[gi] <= hist_shifted;
    end
  end

  assign rd_data = hist_q[rd_idx];

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_idx != $past(rd_idx)) || (rd_data == $past(rd_data))); // R7

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_idx) |=> (rd_idx != $past(rd_idx)) ||
      (rd_data == {$past(rd_data[HIST_W-2:0]), $past(wr_bit)})); // R2

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_en)); // R2
endmodule

// File: rtl/brconf_zcount.sv
module brconf_zcount #(
  parameter int HIST_W = 8,
  parameter int CNT_W  = $clog2(HIST_W + 1)
) (
  input  logic [HIST_W-1:0] hist,
  output logic [CNT_W-1:0]  zeros
);
  always_comb begin
    zeros = '0;
    for (int i = 0; i < HIST_W; i++) begin
      zeros = zeros + {{(CNT_W-1){1'b0}}, ~hist[i]};
    end
  end

  always_comb begin
    AST_COUNT_RANGE: assert (zeros <= CNT_W'(HIST_W)); // R3
  end
endmodule

// File: rtl/brconf_decide.sv
module brconf_decide
  import brconf_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             mode_weak,
  input  logic [1:0]       ctr,
  input  logic [CNT_W-1:0] zeros,
  input  logic [CNT_W-1:0] thresh,
  output logic             high
);
  logic hist_high;
  logic weak_high;

  always_comb begin
    hist_high = (zeros <= thresh);
    weak_high = !ctr_is_weak(ctr);
    high      = mode_weak ? weak_high : hist_high;
  end
endmodule

// File: rtl/brconf_est.sv
module brconf_est
  import brconf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int HIST_W    = 8,
  parameter int ALIGN_LSB = 2,
  parameter int CNT_W     = $clog2(HIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_weak,
  input  logic [CNT_W-1:0]  thresh,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_ctr,
  output logic              lk_high,
  output logic [CNT_W-1:0]  lk_zeros,
  input  logic              tr_valid,
  input  logic [ADDR_W-1:0] tr_addr,
  input  logic              tr_correct
);
  logic              rst_n_sync;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  tr_idx;
  logic [HIST_W-1:0] lk_hist;
  logic              unused_addr_bits;

  assign lk_idx = lk_addr[ALIGN_LSB +: IDX_W];
  assign tr_idx = tr_addr[ALIGN_LSB +: IDX_W];
  assign unused_addr_bits = ^{lk_addr, tr_addr};

  brconf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  brconf_hist_tbl #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (tr_valid),
    .wr_idx  (tr_idx),
    .wr_bit  (tr_correct),
    .rd_idx  (lk_idx),
    .rd_data (lk_hist)
  );

  brconf_zcount #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_cnt (
    .hist  (lk_hist),
    .zeros (lk_zeros)
  );

  brconf_decide #(.CNT_W(CNT_W)) u_dec (
    .mode_weak (mode_weak),
    .ctr       (lk_ctr),
    .zeros     (lk_zeros),
    .thresh    (thresh),
    .high      (lk_high)
  );

  AST_THRESH_HIGH: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!mode_weak && lk_zeros <= thresh) |-> lk_high); // R4

  AST_THRESH_LOW: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!mode_weak && lk_zeros > thresh) |-> !lk_high); // R4

  AST_WEAK_LOW: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_weak && (lk_ctr == CTR_WEAK_NT || lk_ctr == CTR_WEAK_T)) |-> !lk_high); // R5

  AST_STRONG_HIGH: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_weak && (lk_ctr == CTR_STRONG_NT || lk_ctr == CTR_STRONG_T)) |-> lk_high); // R5

  AST_FRESH_FULL: assert property (@(posedge clk)
    $rose(rst_n_sync) |-> (lk_zeros == '0)); // R1
endmodule

// File: tb/brconf_est_tb_top.sv
`timescale 1ns/1ps
module brconf_est_tb_top;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 6;
  localparam int HIST_W = 8;
  localparam int CNT_W  = 4;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mode_weak;
  logic [CNT_W-1:0]  thresh;
  logic [ADDR_W-1:0] lk_addr;
  logic [1:0]        lk_ctr;
  logic              lk_high;
  logic [CNT_W-1:0]  lk_zeros;
  logic              tr_valid;
  logic [ADDR_W-1:0] tr_addr;
  logic              tr_correct;

  int n_vec  = 0;
  int n_fail = 0;
  logic [HIST_W-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  brconf_est dut_i (
    .clk(clk), .rst_n(rst_n), .mode_weak(mode_weak), .thresh(thresh),
    .lk_addr(lk_addr), .lk_ctr(lk_ctr), .lk_high(lk_high), .lk_zeros(lk_zeros),
    .tr_valid(tr_valid), .tr_addr(tr_addr), .tr_correct(tr_correct)
  );

  function automatic int idx_of(input logic [ADDR_W-1:0] a);
    return int'(a[IDX_W+1:2]);
  endfunction

  function automatic int zeros_of(input logic [HIST_W-1:0] h);
    int z = 0;
    for (int i = 0; i < HIST_W; i++) if (!h[i]) z++;
    return z;
  endfunction

  function automatic logic high_of(input logic m, input logic [1:0] c,
                                   input int z, input int th);
    if (m) return !(c == 2'b01 || c == 2'b10);
    return z <= th;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (lk_addr=%h)", tag, act, exp, lk_addr);
    end
  endtask

  // Drive one cycle: lookup is checked before the edge, training lands at the edge.
  task automatic step(input string tag, input logic [ADDR_W-1:0] la,
                      input logic [1:0] lc, input logic tv,
                      input logic [ADDR_W-1:0] ta, input logic tc);
    int z;
    @(negedge clk);
    lk_addr = la; lk_ctr = lc; tr_valid = tv; tr_addr = ta; tr_correct = tc;
    #1;
    z = zeros_of(model[idx_of(la)]);
    check({tag, "/R3 count"}, int'(lk_zeros), z);
    check({tag, "/R4R5 conf"}, int'(lk_high), int'(high_of(mode_weak, lc, z, int'(thresh))));
    if (tv) model[idx_of(ta)] = {model[idx_of(ta)][HIST_W-2:0], tc};
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    rst_n = 1'b0; mode_weak = 1'b0; thresh = '0; lk_addr = '0; lk_ctr = 2'b00;
    tr_valid = 1'b0; tr_addr = '0; tr_correct = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: every entry all ones after reset, high even with threshold 0
    for (int i = 0; i < DEPTH; i++) step("R1", ADDR_W'(i << 2), 2'b00, 1'b0, '0, 1'b0);

    // R2: one wrong outcome into entry 5, entry 6 untouched
    step("R2", 32'h14, 2'b00, 1'b1, 32'h14, 1'b0);
    step("R2", 32'h14, 2'b00, 1'b0, '0, 1'b1);
    check("R2 neighbour", 0, zeros_of(model[6]));
    step("R2", 32'h18, 2'b00, 1'b0, '0, 1'b1);

    // R6: lookup of entry being trained sees the old value
    step("R6", 32'h14, 2'b00, 1'b1, 32'h14, 1'b0);
    check("R6 old", int'(lk_zeros), 1);
    step("R6", 32'h14, 2'b00, 1'b0, '0, 1'b1);
    check("R6 new", int'(lk_zeros), 2);

    // R7: no write while tr_valid is low
    for (int k = 0; k < 4; k++) step("R7", 32'h14, 2'b00, 1'b0, 32'h14, 1'b0);
    check("R7 held", int'(lk_zeros), 2);

    // R8: aliasing addresses share an entry
    step("R8", 32'hABCD_0024, 2'b00, 1'b1, 32'h1234_5624, 1'b0);
    step("R8", 32'hFFFF_FF27, 2'b00, 1'b0, '0, 1'b1);
    check("R8 alias", int'(lk_zeros), 1);

    // R3: saturation after long misprediction burst
    for (int k = 0; k < HIST_W + 3; k++) step("R3", 32'h24, 2'b00, 1'b1, 32'h24, 1'b0);
    step("R3", 32'h24, 2'b00, 1'b0, '0, 1'b1);
    check("R3 sat", int'(lk_zeros), HIST_W);
    // R2: correct outcomes push zeros out one at a time
    step("R2", 32'h24, 2'b00, 1'b1, 32'h24, 1'b1);
    step("R2", 32'h24, 2'b00, 1'b0, '0, 1'b1);
    check("R2 recover", int'(lk_zeros), HIST_W - 1);

    // R4: threshold boundary at count 2 (entry 5)
    thresh = 4'd2; step("R4", 32'h14, 2'b00, 1'b0, '0, 1'b1);
    check("R4 equal", int'(lk_high), 1);
    thresh = 4'd1; step("R4", 32'h14, 2'b00, 1'b0, '0, 1'b1);
    check("R4 above", int'(lk_high), 0);

    // R4 random history mode
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] la, ta;
      if (n % 200 == 0) thresh = CNT_W'($urandom_range(0, HIST_W));
      la = {$urandom, 2'b00}; la[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
      ta = {$urandom, 2'b00}; ta[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
      step("R4 rnd", la, 2'($urandom), 1'($urandom), ta, ($urandom_range(0, 9) < 6));
    end

    // R5: weak-state mode, history still trained
    mode_weak = 1'b1; thresh = 4'd0;
    step("R5", 32'h24, 2'b01, 1'b0, '0, 1'b1); check("R5 weak", int'(lk_high), 0);
    step("R5", 32'h24, 2'b11, 1'b0, '0, 1'b1); check("R5 strong", int'(lk_high), 1);
    step("R5", 32'h0,  2'b10, 1'b0, '0, 1'b1); check("R5 weak full", int'(lk_high), 0);
    step("R5", 32'h0,  2'b00, 1'b0, '0, 1'b1); check("R5 strong nt", int'(lk_high), 1);
    for (int n = 0; n < 1000; n++) begin
      logic [ADDR_W-1:0] la, ta;
      la = {$urandom, 2'b00}; la[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
      ta = {$urandom, 2'b00}; ta[IDX_W+1:2] = IDX_W'($urandom_range(0, 7));
      step("R5 rnd", la, 2'($urandom), 1'($urandom), ta, 1'($urandom));
    end
    mode_weak = 1'b0;
    for (int i = 0; i < 8; i++) step("R5 trained", ADDR_W'(i << 2), 2'b00, 1'b0, '0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule